// File: doc/BRIEF.md
# Serial Register Port with Ready Indication

This block is the slave end of a three- or four-wire serial link in front of a converter. A host drives a select line, a serial clock and a data-in line. The block drives one data-out line, which carries two things: register contents during a read, and a low-active "result available" flag between transfers. The block samples the serial pins with the system clock, so the serial clock has to be several times slower than the system clock.

Every access begins with a one-byte command. The command says whether the access is a read or a write and which register it targets. The block then shifts the right number of bits to or from that register. Three registers are reachable:

- a 16-bit mode register, whose low nibble selects the output word rate and mains rejection;
- a 16-bit configuration register;
- a read-only result register, written by the converter through a one-cycle strobe.

A continuous-read mode streams each new result out without any command. A run of 32 ones on the data input brings the byte framing back into step when the select line is tied low.

Top module: `serial_reg_port`

## Requirements
- R1: After reset the mode register holds 0x000A, the configuration register holds 0x0710, and the ready flag is high (no result).
- R2: `dout_oe` is low while the synchronised `cs_n` is high and high while it is low. With `dout_oe` high and no read bit being shifted, `dout` equals the active-low ready flag.
- R3: The command byte is laid out as follows: bit 7 must be 0, otherwise the byte is ignored and the next byte is taken as a command; bit 6 is 1 for a read; bits 5:3 are the address; bit 2 requests continuous read. The addresses are 1 = mode (16 bits), 2 = configuration (16 bits) and 3 = result (DATA_W bits, read-only). Any other address moves 8 bits, ignores the written data and reads as zero.
- R4: One cycle after a `conv_valid` strobe the ready flag is low, and the result register holds `conv_data`.
- R5: After the last bit of a result-register read, the ready flag returns high.
- R6: A `pre_update` strobe returns the ready flag high when the result has not been read.
- R7: Outside continuous-read mode the result register may be read again with the same value, including after the flag has gone high.
- R8: A write to the mode or configuration register takes effect after its last data bit. A write to the result register changes nothing.
- R9: Read data is sent MSB first. A bit changes after a falling serial-clock edge. Input bits are sampled on rising edges.
- R10: `rej_mode` decodes mode bits 3:0, with bit 0 meaning 50 Hz rejection and bit 1 meaning 60 Hz rejection: 1010 gives 11, 1001 gives 01, 1000 gives 10, and any other value gives 00.
- R11: Command 0x5C enters continuous read. In that mode each `conv_valid` loads the result for shifting without a command. Each result is sent once; clocking with no new result returns the ready flag (ones).
- R12: If the first 8 input bits of a continuous-read transfer form 0x58, the port returns to waiting for a command when that transfer ends.
- R13: 32 consecutive ones sampled on `din` return the port to waiting for a command byte. Register contents are unchanged.
- R14: While `cs_n` is high, serial-clock edges are ignored and the framing state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data or active-low ready flag |
| dout_oe | output | 1 | Output enable for the `dout` pad driver |
| conv_valid | input | 1 | One-cycle strobe: new result present |
| conv_data | input | DATA_W | Offset-binary conversion result |
| pre_update | input | 1 | One-cycle strobe shortly before the next result |
| mode_reg | output | 16 | Mode register contents |
| cfg_reg | output | 16 | Configuration register contents |
| rej_mode | output | 2 | Decoded mains rejection selection |

## Verification
The hardest condition to reach from the pins is a loss of byte alignment that only the 32-ones rule can repair. The bench creates it deliberately by sending three stray zero bits and then 32 ones. With the rule working, those ones are first taken as a write command to the read-only result register and its discarded data, and the ones counter then re-aligns the port. A misaligned port would garble the register read that follows. Continuous-read exit is reached by a result strobe followed by a transfer whose first byte is the exit command. After it, an ordinary register read must succeed.

// File: rtl/srp_pkg.sv
// Shared constants and types for the serial register port.
// Assumes a one-byte command with address in bits 5:3.
package srp_pkg;
    localparam logic [2:0] ADDR_MODE   = 3'd1;
    localparam logic [2:0] ADDR_CFG    = 3'd2;
    localparam logic [2:0] ADDR_DATA   = 3'd3;
    localparam logic [7:0] CR_EXIT_CMD = 8'h58;
    localparam int         CMD_BITS    = 8;
    localparam int         ONES_LIMIT  = 32;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_WR,
        ST_RD,
        ST_CR_WAIT,
        ST_CR_SHIFT
    } port_state_e;
endpackage

// File: rtl/srp_sync_edge.sv
// Synchronises the serial pins into clk and detects serial-clock edges.
// Assumes sclk is slower than clk by at least a factor of four.
module srp_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic din,
    input  logic cs_n,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic din_s,
    output logic cs_n_s
);
    logic [STAGES-1:0] sclk_p;
    logic [STAGES-1:0] din_p;
    logic [STAGES-1:0] cs_p;
    logic              sclk_last;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage capture of the three pins.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sclk_p <= '1;
                    din_p  <= '0;
                    cs_p   <= '1;
                end else begin
                    sclk_p <= sclk;
                    din_p  <= din;
                    cs_p   <= cs_n;
                end
            end
        end else begin : g_chain
            // Multi-stage shift chain per pin.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sclk_p <= '1;
                    din_p  <= '0;
                    cs_p   <= '1;
                end else begin
                    sclk_p <= {sclk_p[STAGES-2:0], sclk};
                    din_p  <= {din_p[STAGES-2:0], din};
                    cs_p   <= {cs_p[STAGES-2:0], cs_n};
                end
            end
        end
    endgenerate

    // Previous synchronised serial-clock level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_last <= 1'b1;
        else        sclk_last <= sclk_p[STAGES-1];
    end

    assign sclk_rise = sclk_p[STAGES-1] & ~sclk_last;
    assign sclk_fall = ~sclk_p[STAGES-1] & sclk_last;
    assign din_s     = din_p[STAGES-1];
    assign cs_n_s    = cs_p[STAGES-1];
endmodule

// File: rtl/srp_ready.sv
// Holds the latest result and the active-low ready flag.
// Assumes conv_valid, pre_update and read_done are single-cycle strobes.
module srp_ready #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              pre_update,
    input  logic              read_done,
    output logic              rdy_n,
    output logic [DATA_W-1:0] data_q
);
    // A new result takes priority; a read or imminent update clears the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_n  <= 1'b1;
            data_q <= '0;
        end else if (conv_valid) begin
            rdy_n  <= 1'b0;
            data_q <= conv_data;
        end else if (read_done || pre_update) begin
            rdy_n  <= 1'b1;
        end
    end

    assert_ready_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |=> !rdy_n);
    assert_ready_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        read_done && !conv_valid |=> rdy_n);
    assert_stale_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pre_update && !conv_valid |=> rdy_n);
    assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_valid |=> $stable(data_q));
endmodule

// File: rtl/srp_regs.sv
// Mode and configuration registers with the rejection decode.
// Assumes wr_en is a one-cycle strobe carrying a complete 16-bit word.
module srp_regs
    import srp_pkg::*;
#(
    parameter logic [15:0] MODE_RST = 16'h000A,
    parameter logic [15:0] CFG_RST  = 16'h0710
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [15:0] wr_data,
    output logic [15:0] mode_q,
    output logic [15:0] cfg_q,
    output logic [1:0]  rej_mode
);
    // Register update on a completed write; other addresses are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
            cfg_q  <= CFG_RST;
        end else if (wr_en) begin
            if (wr_addr == ADDR_MODE) mode_q <= wr_data;
            if (wr_addr == ADDR_CFG)  cfg_q  <= wr_data;
        end
    end

    // Map the rate field onto the two rejection notches.
    always_comb begin
        unique case (mode_q[3:0])
            4'b1010: rej_mode = 2'b11;
            4'b1001: rej_mode = 2'b01;
            4'b1000: rej_mode = 2'b10;
            default: rej_mode = 2'b00;
        endcase
    end

    assert_mode_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == ADDR_MODE |=> mode_q == $past(wr_data));
    assert_ro_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == ADDR_DATA |=> $stable(mode_q) && $stable(cfg_q));
endmodule

// File: rtl/srp_ctrl.sv
// Framing state machine: command decode, shifting in and out,
// continuous read and the ones-run resynchronisation.
// Assumes edge strobes come from srp_sync_edge and never coincide.
module srp_ctrl
    import srp_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din_s,
    input  logic              cs_n_s,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_data,
    input  logic [15:0]       mode_q,
    input  logic [15:0]       cfg_q,
    input  logic [DATA_W-1:0] data_q,
    output logic              wr_en,
    output logic [2:0]        wr_addr,
    output logic [15:0]       wr_data,
    output logic              read_done,
    output logic              drv_en,
    output logic              drv_bit
);
    localparam int SH_W   = (DATA_W > 16) ? DATA_W : 16;
    localparam int CNT_W  = $clog2(SH_W + 1);
    localparam int ONES_W = $clog2(ONES_LIMIT + 1);

    port_state_e       state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CNT_W-1:0]  nbits;
    logic [14:0]       sh_in;
    logic [15:0]       in_nx;
    logic [7:0]        cmd_nx;
    logic [SH_W-1:0]   sh_out;
    logic [2:0]        addr_q;
    logic [ONES_W-1:0] ones_cnt;
    logic              exit_pend;
    logic              act_rise;
    logic              act_fall;
    logic              flush;
    logic              last_bit;
    logic              cmd_done;

    assign act_rise = sclk_rise & ~cs_n_s;
    assign act_fall = sclk_fall & ~cs_n_s;
    assign in_nx    = {sh_in, din_s};
    assign cmd_nx   = in_nx[7:0];
    assign flush    = act_rise & din_s & (ones_cnt == ONES_W'(ONES_LIMIT - 1));
    assign last_bit = (bit_cnt == nbits - CNT_W'(1));
    assign cmd_done = (bit_cnt == CNT_W'(CMD_BITS - 1));

    // Transfer length in bits for a register address.
    function automatic logic [CNT_W-1:0] width_of(input logic [2:0] a);
        case (a)
            ADDR_MODE, ADDR_CFG: width_of = CNT_W'(16);
            ADDR_DATA:           width_of = CNT_W'(DATA_W);
            default:             width_of = CNT_W'(CMD_BITS);
        endcase
    endfunction

    // Read value, MSB-aligned at the top of the output shifter.
    function automatic logic [SH_W-1:0] rd_aligned(input logic [2:0] a);
        case (a)
            ADDR_MODE: rd_aligned = SH_W'(mode_q) << (SH_W - 16);
            ADDR_CFG:  rd_aligned = SH_W'(cfg_q) << (SH_W - 16);
            ADDR_DATA: rd_aligned = SH_W'(data_q) << (SH_W - DATA_W);
            default:   rd_aligned = '0;
        endcase
    endfunction

    // Count consecutive ones sampled on active rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ones_cnt <= '0;
        else if (act_rise)          ones_cnt <= (din_s && !flush) ? ones_cnt + ONES_W'(1) : '0;
    end

    // Main framing engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_CMD;
            bit_cnt   <= '0;
            nbits     <= CNT_W'(CMD_BITS);
            sh_in     <= '0;
            sh_out    <= '0;
            addr_q    <= '0;
            exit_pend <= 1'b0;
            drv_en    <= 1'b0;
            drv_bit   <= 1'b1;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            read_done <= 1'b0;
        end else begin
            wr_en     <= 1'b0;
            read_done <= 1'b0;
            if (flush) begin
                state     <= ST_CMD;
                bit_cnt   <= '0;
                drv_en    <= 1'b0;
                exit_pend <= 1'b0;
            end else if (state == ST_CR_WAIT && conv_valid) begin
                sh_out  <= SH_W'(conv_data) << (SH_W - DATA_W);
                bit_cnt <= '0;
                nbits   <= CNT_W'(DATA_W);
                state   <= ST_CR_SHIFT;
            end else if (act_rise) begin
                unique case (state)
                    ST_CMD: begin
                        sh_in <= in_nx[14:0];
                        if (cmd_done) begin
                            bit_cnt <= '0;
                            if (!cmd_nx[7]) begin
                                addr_q <= cmd_nx[5:3];
                                nbits  <= width_of(cmd_nx[5:3]);
                                if (!cmd_nx[6]) begin
                                    state <= ST_WR;
                                end else if (cmd_nx[5:3] == ADDR_DATA && cmd_nx[2]) begin
                                    state <= ST_CR_WAIT;
                                end else begin
                                    state  <= ST_RD;
                                    sh_out <= rd_aligned(cmd_nx[5:3]);
                                end
                            end
                        end else begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                    ST_WR: begin
                        sh_in <= in_nx[14:0];
                        if (last_bit) begin
                            bit_cnt <= '0;
                            state   <= ST_CMD;
                            wr_en   <= 1'b1;
                            wr_addr <= addr_q;
                            wr_data <= in_nx;
                        end else begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                    ST_RD: begin
                        if (last_bit) begin
                            bit_cnt   <= '0;
                            state     <= ST_CMD;
                            drv_en    <= 1'b0;
                            read_done <= (addr_q == ADDR_DATA);
                        end else begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                    ST_CR_SHIFT: begin
                        sh_in <= in_nx[14:0];
                        if (cmd_done && cmd_nx == CR_EXIT_CMD) exit_pend <= 1'b1;
                        if (last_bit) begin
                            bit_cnt   <= '0;
                            drv_en    <= 1'b0;
                            read_done <= 1'b1;
                            exit_pend <= 1'b0;
                            state     <= exit_pend ? ST_CMD : ST_CR_WAIT;
                        end else begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end else if (act_fall && (state == ST_RD || state == ST_CR_SHIFT)) begin
                drv_bit <= sh_out[SH_W-1];
                sh_out  <= sh_out << 1;
                drv_en  <= 1'b1;
            end
        end
    end

    assert_cs_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s && state != ST_CR_WAIT |=> $stable(state) && $stable(bit_cnt));
    assert_drive_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (state == ST_RD || state == ST_CR_SHIFT));
    assert_bad_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_rise && !flush && state == ST_CMD && cmd_done && cmd_nx[7] |=> state == ST_CMD);
    assert_flush_R13: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> state == ST_CMD && bit_cnt == '0);
endmodule

// File: rtl/serial_reg_port.sv
// Top of the serial register port. It joins the pin synchroniser,
// framing engine, register bank and ready tracker, and muxes the
// shared data-out line.
// Assumes the pad supplies the tri-state using dout_oe.
module serial_reg_port #(
    parameter int          DATA_W      = 24,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] MODE_RST    = 16'h000A,
    parameter logic [15:0] CFG_RST     = 16'h0710
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic              dout,
    output logic              dout_oe,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              pre_update,
    output logic [15:0]       mode_reg,
    output logic [15:0]       cfg_reg,
    output logic [1:0]        rej_mode
);
    logic              sclk_rise;
    logic              sclk_fall;
    logic              din_s;
    logic              cs_n_s;
    logic              wr_en;
    logic [2:0]        wr_addr;
    logic [15:0]       wr_data;
    logic              read_done;
    logic              drv_en;
    logic              drv_bit;
    logic              rdy_n;
    logic [DATA_W-1:0] data_q;

    srp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(din), .cs_n(cs_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .din_s(din_s), .cs_n_s(cs_n_s)
    );

    srp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .din_s(din_s), .cs_n_s(cs_n_s), .conv_valid(conv_valid), .conv_data(conv_data),
        .mode_q(mode_reg), .cfg_q(cfg_reg), .data_q(data_q),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .read_done(read_done), .drv_en(drv_en), .drv_bit(drv_bit)
    );

    srp_regs #(.MODE_RST(MODE_RST), .CFG_RST(CFG_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mode_q(mode_reg), .cfg_q(cfg_reg), .rej_mode(rej_mode)
    );

    srp_ready #(.DATA_W(DATA_W)) u_ready (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_data(conv_data),
        .pre_update(pre_update), .read_done(read_done), .rdy_n(rdy_n), .data_q(data_q)
    );

    // Data-out carries shifted bits during a read, the ready flag otherwise.
    assign dout    = drv_en ? drv_bit : rdy_n;
    assign dout_oe = ~cs_n_s;
endmodule

// File: tb/tb_serial_reg_port.sv
module tb_serial_reg_port;
    localparam int DATA_W = 24;
    localparam int HALF   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              sclk = 1'b1;
    logic              din = 1'b0;
    logic              dout;
    logic              dout_oe;
    logic              conv_valid = 1'b0;
    logic [DATA_W-1:0] conv_data = '0;
    logic              pre_update = 1'b0;
    logic [15:0]       mode_reg;
    logic [15:0]       cfg_reg;
    logic [1:0]        rej_mode;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    logic [15:0]       mode_m = 16'h000A;
    logic [15:0]       cfg_m  = 16'h0710;
    logic [DATA_W-1:0] data_m = '0;

    serial_reg_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout(dout), .dout_oe(dout_oe), .conv_valid(conv_valid), .conv_data(conv_data),
        .pre_update(pre_update), .mode_reg(mode_reg), .cfg_reg(cfg_reg), .rej_mode(rej_mode)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 180000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [1:0] exp_rej(input logic [3:0] rate);
        case (rate)
            4'b1010: return 2'b11;
            4'b1001: return 2'b01;
            4'b1000: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [31:0] tx, input int n, output logic [31:0] rx);
        rx = '0;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            sclk = 1'b0;
            din  = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = dout;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        din = 1'b0;
    endtask

    task automatic write_reg(input logic [2:0] addr, input logic [31:0] val, input int n);
        logic [31:0] rx;
        xfer({24'd0, 2'b00, addr, 3'b000}, 8, rx);
        xfer(val, n, rx);
    endtask

    task automatic read_reg(input logic [2:0] addr, input int n, output logic [31:0] rx);
        logic [31:0] tmp;
        xfer({24'd0, 2'b01, addr, 3'b000}, 8, tmp);
        xfer(32'd0, n, rx);
    endtask

    task automatic conv(input logic [DATA_W-1:0] d);
        @(negedge clk);
        conv_valid = 1'b1;
        conv_data  = d;
        @(negedge clk);
        conv_valid = 1'b0;
        data_m = d;
    endtask

    initial begin
        logic [31:0] rx;
        logic [15:0] mv;
        logic [15:0] cv;
        logic [DATA_W-1:0] dv;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Reset state and output enable
        check("R2 oe low while deselected", dout_oe, 0);
        check("R1 mode reset", mode_reg, 16'h000A);
        check("R1 cfg reset", cfg_reg, 16'h0710);
        check("R10 reset rejection", rej_mode, 2'b11);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 oe high while selected", dout_oe, 1);
        check("R1 ready idle high on dout", dout, 1);

        // Register access
        read_reg(3'd1, 16, rx);
        check("R9 mode readback msb first", rx, 32'h000A);
        write_reg(3'd1, 32'h1234, 16); mode_m = 16'h1234;
        check("R8 mode write", mode_reg, mode_m);
        read_reg(3'd1, 16, rx);
        check("R9 mode readback", rx, mode_m);
        write_reg(3'd2, 32'hBEEF, 16); cfg_m = 16'hBEEF;
        read_reg(3'd2, 16, rx);
        check("R8 cfg readback", rx, cfg_m);
        write_reg(3'd1, 32'h0009, 16); mode_m = 16'h0009;
        check("R10 50 Hz", rej_mode, 2'b01);
        write_reg(3'd1, 32'h0008, 16); mode_m = 16'h0008;
        check("R10 60 Hz", rej_mode, 2'b10);
        write_reg(3'd1, 32'h0005, 16); mode_m = 16'h0005;
        check("R10 no notch", rej_mode, 2'b00);

        // Unknown address and rejected command byte
        read_reg(3'd5, 8, rx);
        check("R3 unknown address reads zero", rx, 0);
        write_reg(3'd5, 32'hA5, 8);
        check("R3 unknown write mode", mode_reg, mode_m);
        check("R3 unknown write cfg", cfg_reg, cfg_m);
        xfer(32'h88, 8, rx);
        read_reg(3'd1, 16, rx);
        check("R3 bit7 command ignored", rx, mode_m);

        // Ready flag and result reads
        conv(24'hA5C3E1);
        repeat (4) @(negedge clk);
        check("R4 ready low after result", dout, 0);
        read_reg(3'd3, DATA_W, rx);
        check("R4 result value", rx, 32'(data_m));
        check("R5 ready high after read", dout, 1);
        read_reg(3'd3, DATA_W, rx);
        check("R7 reread result", rx, 32'(data_m));
        conv(24'h800001);
        repeat (4) @(negedge clk);
        check("R4 ready low again", dout, 0);
        @(negedge clk); pre_update = 1'b1;
        @(negedge clk); pre_update = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 stale result flag high", dout, 1);
        read_reg(3'd3, DATA_W, rx);
        check("R7 read after stale clear", rx, 32'(data_m));
        write_reg(3'd3, 32'h123456, DATA_W);
        read_reg(3'd3, DATA_W, rx);
        check("R8 result register read-only", rx, 32'(data_m));

        // Deselected clocks are ignored
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 oe released", dout_oe, 0);
        xfer(32'h08, 8, rx);
        xfer(32'h0000, 16, rx);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R14 mode untouched", mode_reg, mode_m);
        read_reg(3'd1, 16, rx);
        check("R14 framing intact", rx, mode_m);

        // Ones run realigns the framing
        xfer(32'h0, 3, rx);
        xfer(32'hFFFFFFFF, 32, rx);
        read_reg(3'd1, 16, rx);
        check("R13 realigned read", rx, mode_m);
        check("R13 registers kept", cfg_reg, cfg_m);

        // Random register and result traffic
        for (int it = 0; it < 12; it++) begin
            mv = 16'($urandom);
            if ($urandom % 4 != 0) mv[3:0] = 4'd8 + 4'($urandom % 3);
            cv = 16'($urandom);
            dv = DATA_W'($urandom);
            write_reg(3'd1, {16'd0, mv}, 16); mode_m = mv;
            check("R10 random decode", rej_mode, exp_rej(mv[3:0]));
            write_reg(3'd2, {16'd0, cv}, 16); cfg_m = cv;
            read_reg(3'd1, 16, rx);
            check("R8 random mode", rx, mode_m);
            read_reg(3'd2, 16, rx);
            check("R8 random cfg", rx, cfg_m);
            conv(dv);
            read_reg(3'd3, DATA_W, rx);
            check("R9 random result", rx, 32'(data_m));
            check("R5 random ready clear", dout, 1);
        end

        // Continuous read
        write_reg(3'd1, 32'h0C0A, 16); mode_m = 16'h0C0A;
        xfer(32'h5C, 8, rx);
        conv(24'h3C5A96);
        repeat (4) @(negedge clk);
        check("R11 ready low in stream", dout, 0);
        xfer(32'h0, DATA_W, rx);
        check("R11 streamed result", rx, 32'(data_m));
        check("R11 ready high after stream", dout, 1);
        xfer(32'h0, DATA_W, rx);
        check("R11 result sent once", rx, 32'hFFFFFF);
        conv(24'h0F1E2D);
        xfer({8'd0, 8'h58, 16'h0000}, DATA_W, rx);
        check("R12 last streamed result", rx, 32'(data_m));
        read_reg(3'd1, 16, rx);
        check("R12 command mode restored", rx, mode_m);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule